// File: doc/BRIEF.md
# Compacted Segment Reader

This block serves a compressed cache set in which every block of a super block is packed tightly into shared 16-byte segments. A block may start partway through a segment, right after the end of the block stored before it. Each segment carries an owner tag index and a four-bit vector that marks which blocks of that super block have bytes in it. For a read request, the block finds the qualifying segments and visits them in ascending index order. It takes bytes from the block's start offset onward and stops at the length given by the compression type. The result appears, zero-padded to 64 bytes, one clock after the request.

A second, purely combinational path supports the allocator. From the super block's last-used-byte field and the compression type of a block about to be appended, it reports four things: where the new block starts, whether its first byte lands in a fresh segment, how many new segments it needs, and the new last-used-byte value. Tag lookup, victim choice and decompression are done elsewhere.

Top module: `ccmp_seg_reader`

## Requirements
- R1: `rd_valid` equals `req_valid` delayed by one clock. While `rst` is high, `rd_valid`, `rd_data` and `rd_segs` are cleared to zero.
- R2: Segment i qualifies when all three of these hold:
  - `seg_valid[i]` is 1.
  - `seg_tag[i*TAG_W +: TAG_W]` equals `req_tag`.
  - Bit `req_blk` of `seg_sharers[i*4 +: 4]` is set, where bit n stands for block n.

  `rd_segs` reports how many segments qualify.
- R3: Byte j of the result sits at `rd_data[8j +: 8]`. Byte b of segment i is `seg_data[i*128 + 8b +: 8]`. Result byte 0 is byte `req_begin mod 16` of the lowest-indexed qualifying segment.
- R4: After byte 15 of a qualifying segment, the result continues at byte 0 of the next qualifying segment by index. No bytes are skipped.
- R5: Compression type c (0..3) gives a length of 16*(c+1) bytes. Every result byte at or beyond that length is zero.
- R6: Only `req_begin mod 16` sets the start position. Bits 6..4 of `req_begin` have no effect on the result.
- R7: Result bytes that would come from qualifying segments beyond the last one read as zero. With no qualifying segment, the whole result is zero.
- R8: When no request is made, `rd_data` and `rd_segs` keep their previous values.
- R9: `app_begin` is `(app_end + 1) mod 16`. `app_fresh` is 1 exactly when `app_end` is 15.
- R10: `app_segs` is `app_ctype + 1`. `app_end_next` is `(app_begin + 16*(app_ctype+1) - 1) mod 16`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request strobe |
| req_tag | input | TAG_W | Tag index of the requested super block |
| req_blk | input | 2 | Block number within the super block |
| req_begin | input | 7 | Stored start byte of the block |
| req_ctype | input | 2 | Compression type of the block |
| seg_valid | input | NUM_SEGS | Per-segment valid bits |
| seg_tag | input | NUM_SEGS*TAG_W | Per-segment owner tag index |
| seg_sharers | input | NUM_SEGS*4 | Per-segment block-presence vectors |
| seg_data | input | NUM_SEGS*128 | Segment contents |
| rd_valid | output | 1 | Result valid |
| rd_data | output | 512 | Extracted block, zero-padded |
| rd_segs | output | $clog2(NUM_SEGS+1) | Number of qualifying segments |
| app_end | input | 4 | Super block last-used byte |
| app_ctype | input | 2 | Compression type of the block being appended |
| app_begin | output | 4 | Start byte of the appended block |
| app_fresh | output | 1 | Appended block begins in a new segment |
| app_segs | output | 3 | New segments the append needs |
| app_end_next | output | 4 | Last-used byte after the append |

## Verification
A fault in the segment ordering or piece compaction shows up in the very next registered result as shifted or swapped 16-byte runs, because every read exercises it. Faults in the start shift or the length mask show up as wrong bytes at the head or tail of `rd_data` in that same cycle. A stuck `rd_data` register shows up only when a later request carries different data. The append outputs are combinational, so a fault there is visible as soon as `app_end` or `app_ctype` changes.

// File: rtl/ccmp_pkg.sv
package ccmp_pkg;

    localparam int SEG_BYTES = 16;
    localparam int SEG_BITS  = SEG_BYTES * 8;
    localparam int BLKS      = 4;
    localparam int BLK_W     = $clog2(BLKS);
    localparam int OFF_W     = $clog2(SEG_BYTES);
    localparam int BEGIN_W   = 7;
    localparam int MAX_BYTES = 64;
    localparam int MAX_BITS  = MAX_BYTES * 8;
    // worst case: block starts at last byte of a segment and is full length
    localparam int PIECES    = (SEG_BYTES - 1 + MAX_BYTES + SEG_BYTES - 1) / SEG_BYTES;
    localparam int NSEG_W    = $clog2(MAX_BYTES / SEG_BYTES + 1);

    typedef logic [1:0] ctype_t;

    typedef struct packed {
        logic [OFF_W-1:0]  start;
        logic              fresh;
        logic [NSEG_W-1:0] nsegs;
        logic [OFF_W-1:0]  end_next;
    } app_res_t;

    function automatic logic [7:0] size_bytes(input ctype_t c);
        return 8'((int'(c) + 1) * SEG_BYTES);
    endfunction

    function automatic logic [MAX_BITS-1:0] len_mask(input ctype_t c);
        logic [MAX_BITS-1:0] m;
        m = '0;
        for (int j = 0; j < MAX_BYTES; j++)
            if (j < int'(size_bytes(c)))
                m[j*8 +: 8] = 8'hFF;
        return m;
    endfunction

endpackage

// File: rtl/ccmp_seg_match.sv
module ccmp_seg_match
    import ccmp_pkg::*;
#(
    parameter int NUM_SEGS = 8,
    parameter int TAG_W    = 2,
    parameter int CNT_W    = $clog2(NUM_SEGS + 1)
) (
    input  logic [NUM_SEGS-1:0]       seg_valid,
    input  logic [NUM_SEGS*TAG_W-1:0] seg_tag,
    input  logic [NUM_SEGS*BLKS-1:0]  seg_sharers,
    input  logic [TAG_W-1:0]          req_tag,
    input  logic [BLK_W-1:0]          req_blk,
    output logic [NUM_SEGS-1:0]       hit_vec,
    output logic [CNT_W-1:0]          hit_cnt
);

    for (genvar i = 0; i < NUM_SEGS; i++) begin : g_seg
        logic [BLKS-1:0] shr;
        assign shr        = seg_sharers[i*BLKS +: BLKS];
        assign hit_vec[i] = seg_valid[i]
                          && (seg_tag[i*TAG_W +: TAG_W] == req_tag)
                          && shr[req_blk];
    end

    always_comb begin
        hit_cnt = '0;
        for (int i = 0; i < NUM_SEGS; i++)
            hit_cnt = hit_cnt + CNT_W'(hit_vec[i]);
    end

endmodule

// File: rtl/ccmp_gather.sv
module ccmp_gather
    import ccmp_pkg::*;
#(
    parameter int NUM_SEGS = 8
) (
    input  logic [NUM_SEGS-1:0]          hit_vec,
    input  logic [NUM_SEGS*SEG_BITS-1:0] seg_data,
    input  logic [OFF_W-1:0]             start,
    input  ctype_t                       ctype,
    output logic [MAX_BITS-1:0]          blk_data
);

    localparam int PW = $clog2(PIECES + 1);

    logic [PIECES-1:0][SEG_BITS-1:0] pieces;
    logic [PIECES*SEG_BITS-1:0]      stream;
    logic [PIECES*SEG_BITS-1:0]      shifted;
    logic [PW-1:0]                   n;

    // compact qualifying segments, lowest index first, into a byte stream
    always_comb begin
        pieces = '0;
        n      = '0;
        for (int i = 0; i < NUM_SEGS; i++) begin
            if (hit_vec[i] && (n < PW'(PIECES))) begin
                pieces[n] = seg_data[i*SEG_BITS +: SEG_BITS];
                n = n + 1'b1;
            end
        end
        stream   = pieces;
        shifted  = stream >> {start, 3'b000};
        blk_data = shifted[MAX_BITS-1:0] & len_mask(ctype);
    end

endmodule

// File: rtl/ccmp_append.sv
module ccmp_append
    import ccmp_pkg::*;
(
    input  logic [OFF_W-1:0] end_in,
    input  ctype_t           ctype,
    output app_res_t         res
);

    logic [7:0] last_ofs;

    always_comb begin
        res.start    = end_in + 1'b1;
        res.fresh    = (end_in == OFF_W'(SEG_BYTES - 1));
        res.nsegs    = NSEG_W'(int'(ctype) + 1);
        last_ofs     = 8'(res.start) + size_bytes(ctype) - 8'd1;
        res.end_next = last_ofs[OFF_W-1:0];
    end

endmodule

// File: rtl/ccmp_seg_reader.sv
module ccmp_seg_reader
    import ccmp_pkg::*;
#(
    parameter int NUM_SEGS = 8,
    parameter int TAG_W    = 2,
    parameter int CNT_W    = $clog2(NUM_SEGS + 1)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    input  logic [TAG_W-1:0]             req_tag,
    input  logic [1:0]                   req_blk,
    input  logic [6:0]                   req_begin,
    input  logic [1:0]                   req_ctype,
    input  logic [NUM_SEGS-1:0]          seg_valid,
    input  logic [NUM_SEGS*TAG_W-1:0]    seg_tag,
    input  logic [NUM_SEGS*4-1:0]        seg_sharers,
    input  logic [NUM_SEGS*128-1:0]      seg_data,
    output logic                         rd_valid,
    output logic [511:0]                 rd_data,
    output logic [CNT_W-1:0]             rd_segs,
    input  logic [3:0]                   app_end,
    input  logic [1:0]                   app_ctype,
    output logic [3:0]                   app_begin,
    output logic                         app_fresh,
    output logic [2:0]                   app_segs,
    output logic [3:0]                   app_end_next
);

    logic [NUM_SEGS-1:0] hit_vec;
    logic [CNT_W-1:0]    hit_cnt;
    logic [OFF_W-1:0]    start_eff;
    logic [MAX_BITS-1:0] blk_data;
    app_res_t            app_res;

    // only the position within a segment matters
    assign start_eff = OFF_W'(req_begin % BEGIN_W'(SEG_BYTES));

    ccmp_seg_match #(
        .NUM_SEGS(NUM_SEGS), .TAG_W(TAG_W), .CNT_W(CNT_W)
    ) u_match (
        .seg_valid  (seg_valid),
        .seg_tag    (seg_tag),
        .seg_sharers(seg_sharers),
        .req_tag    (req_tag),
        .req_blk    (req_blk),
        .hit_vec    (hit_vec),
        .hit_cnt    (hit_cnt)
    );

    ccmp_gather #(.NUM_SEGS(NUM_SEGS)) u_gather (
        .hit_vec (hit_vec),
        .seg_data(seg_data),
        .start   (start_eff),
        .ctype   (req_ctype),
        .blk_data(blk_data)
    );

    ccmp_append u_append (
        .end_in(app_end),
        .ctype (app_ctype),
        .res   (app_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_segs  <= '0;
        end else begin
            rd_valid <= req_valid;
            if (req_valid) begin
                rd_data <= blk_data;
                rd_segs <= hit_cnt;
            end
        end
    end

    assign app_begin    = app_res.start;
    assign app_fresh    = app_res.fresh;
    assign app_segs     = app_res.nsegs;
    assign app_end_next = app_res.end_next;

endmodule

// File: rtl/ccmp_seg_reader_chk.sv
module ccmp_seg_reader_chk
    import ccmp_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_ctype,
    input logic              rd_valid,
    input logic [511:0]      rd_data,
    input logic [CNT_W-1:0]  rd_segs,
    input logic [3:0]        app_end,
    input logic [3:0]        app_begin,
    input logic              app_fresh,
    input logic [3:0]        app_end_next
);

    AST_RD_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rd_valid);                                        // R1
    AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rd_valid);                                      // R1
    AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ((rd_data & ~len_mask($past(req_ctype))) == '0));  // R5
    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_segs == '0) |-> (rd_data == '0));               // R7
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(rd_data) && $stable(rd_segs)));         // R8
    AST_FRESH_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        app_fresh == (app_begin == 4'd0));                              // R9
    AST_END_PRESERVED: assert property (@(posedge clk) disable iff (rst)
        app_end_next == app_end);                                       // R10

endmodule

bind ccmp_seg_reader ccmp_seg_reader_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ctype   (req_ctype),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .rd_segs     (rd_segs),
    .app_end     (app_end),
    .app_begin   (app_begin),
    .app_fresh   (app_fresh),
    .app_end_next(app_end_next)
);

// File: tb/tb_ccmp_seg_reader.sv
module tb_ccmp_seg_reader;

    localparam int NS = 8;
    localparam int TW = 2;
    localparam int CW = $clog2(NS + 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [TW-1:0]     req_tag = '0;
    logic [1:0]        req_blk = '0;
    logic [6:0]        req_begin = '0;
    logic [1:0]        req_ctype = '0;
    logic [NS-1:0]     seg_valid;
    logic [NS*TW-1:0]  seg_tag;
    logic [NS*4-1:0]   seg_sharers;
    logic [NS*128-1:0] seg_data;
    logic              rd_valid;
    logic [511:0]      rd_data;
    logic [CW-1:0]     rd_segs;
    logic [3:0]        app_end = '0;
    logic [1:0]        app_ctype = '0;
    logic [3:0]        app_begin;
    logic              app_fresh;
    logic [2:0]        app_segs;
    logic [3:0]        app_end_next;

    logic              m_valid [NS];
    logic [TW-1:0]     m_tag   [NS];
    logic [3:0]        m_sh    [NS];
    logic [127:0]      m_data  [NS];

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 0;

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NS; i++) begin
            seg_valid[i]               = m_valid[i];
            seg_tag[i*TW +: TW]        = m_tag[i];
            seg_sharers[i*4 +: 4]      = m_sh[i];
            seg_data[i*128 +: 128]     = m_data[i];
        end
    end

    ccmp_seg_reader #(.NUM_SEGS(NS), .TAG_W(TW)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_tag(req_tag),
        .req_blk(req_blk), .req_begin(req_begin), .req_ctype(req_ctype),
        .seg_valid(seg_valid), .seg_tag(seg_tag), .seg_sharers(seg_sharers),
        .seg_data(seg_data), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_segs(rd_segs), .app_end(app_end), .app_ctype(app_ctype),
        .app_begin(app_begin), .app_fresh(app_fresh), .app_segs(app_segs),
        .app_end_next(app_end_next)
    );

    // requirement-level model: stream position begin+j, piece index = pos/16
    function automatic int exp_count(input logic [TW-1:0] t, input logic [1:0] b);
        int n = 0;
        for (int i = 0; i < NS; i++)
            if (m_valid[i] && m_tag[i] == t && m_sh[i][b]) n++;
        return n;
    endfunction

    function automatic logic [511:0] exp_data(input logic [TW-1:0] t, input logic [1:0] b,
                                              input logic [6:0] bg, input logic [1:0] c);
        int order [NS];
        int n = 0;
        logic [511:0] r = '0;
        for (int i = 0; i < NS; i++)
            if (m_valid[i] && m_tag[i] == t && m_sh[i][b]) begin
                order[n] = i;
                n++;
            end
        for (int j = 0; j < 64; j++) begin
            int pos = int'(bg) % 16 + j;
            if (j < (int'(c) + 1) * 16 && pos / 16 < n)
                r[j*8 +: 8] = m_data[order[pos/16]][(pos%16)*8 +: 8];
        end
        return r;
    endfunction

    task automatic check_bit(input string req, input logic [511:0] act, input logic [511:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a negedge; drives a request and checks one cycle later
    task automatic do_read(input logic [TW-1:0] t, input logic [1:0] b,
                           input logic [6:0] bg, input logic [1:0] c, input string req);
        logic [511:0] e;
        int           ec;
        req_valid = 1'b1; req_tag = t; req_blk = b; req_begin = bg; req_ctype = c;
        e  = exp_data(t, b, bg, c);
        ec = exp_count(t, b);
        @(negedge clk);
        check_bit({req, " rd_valid R1"}, 512'(rd_valid), 512'(1));
        check_bit({req, " count R2"}, 512'(rd_segs), 512'(ec));
        check_bit({req, " data"}, rd_data, e);
    endtask

    task automatic load_cfg(input int kind);
        for (int i = 0; i < NS; i++) begin
            m_data[i] = {$urandom, $urandom, $urandom, $urandom};
            case (kind)
                0: begin m_valid[i] = 1'b0; m_tag[i] = '0; m_sh[i] = 4'hF; end
                1: begin m_valid[i] = 1'b1; m_tag[i] = '0; m_sh[i] = 4'hF; end
                default: begin
                    m_valid[i] = ($urandom % 5) != 0;
                    m_tag[i]   = TW'($urandom % 2);
                    m_sh[i]    = 4'($urandom);
                end
            endcase
        end
    endtask

    initial begin
        logic [511:0] held;
        logic [CW-1:0] held_cnt;
        load_cfg(2);
        repeat (3) @(negedge clk);
        // R1: reset state
        check_bit("reset rd_valid R1", 512'(rd_valid), '0);
        check_bit("reset rd_data R1", rd_data, '0);
        check_bit("reset rd_segs R1", 512'(rd_segs), '0);
        rst = 1'b0;
        @(negedge clk);

        // sweep R2 R3 R4 R5 R7 across configurations
        for (int k = 0; k < 7; k++) begin
            load_cfg(k < 2 ? k : 2);
            for (int t = 0; t < 4; t++)
                for (int b = 0; b < 4; b++)
                    for (int s = 0; s < 16; s++)
                        for (int c = 0; c < 4; c++)
                            do_read(TW'(t), 2'(b), 7'(s), 2'(c), "R3 R4 R5 R7 sweep");
        end

        // R6: upper begin bits ignored
        load_cfg(1);
        for (int s = 0; s < 16; s++)
            for (int u = 1; u < 8; u++)
                do_read('0, 2'(s % 4), {3'(u), 4'(s)}, 2'd3, "R6 upper begin bits");

        // R1: rd_valid drops when no request
        req_valid = 1'b0;
        @(negedge clk);
        check_bit("idle rd_valid R1", 512'(rd_valid), '0);

        // R8: result held while idle, even though segment contents change
        do_read('0, 2'd1, 7'd5, 2'd2, "R8 setup");
        held     = rd_data;
        held_cnt = rd_segs;
        req_valid = 1'b0;
        for (int i = 0; i < NS; i++) begin
            m_data[i] = ~m_data[i];
            m_valid[i] = 1'b0;
        end
        repeat (4) @(negedge clk);
        check_bit("hold rd_data R8", rd_data, held);
        check_bit("hold rd_segs R8", 512'(rd_segs), 512'(held_cnt));

        // R9 R10: exhaustive append sweep
        for (int e = 0; e < 16; e++)
            for (int c = 0; c < 4; c++) begin
                int eb;
                app_end = 4'(e); app_ctype = 2'(c);
                #1;
                eb = (e + 1) % 16;
                check_bit("append begin R9", 512'(app_begin), 512'(eb));
                check_bit("append fresh R9", 512'(app_fresh), 512'(e == 15));
                check_bit("append segs R10", 512'(app_segs), 512'(c + 1));
                check_bit("append end R10", 512'(app_end_next), 512'((eb + (c + 1) * 16 - 1) % 16));
            end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule